// File: doc/BRIEF.md
# Timed IQ Transmit Burst Packetizer

This block sits between a sample source and a radio transmit path. It takes 16-bit in-phase and quadrature samples over a ready/valid handshake and packs each pair into one 32-bit word. It then presents the words on a ready/valid output stream that carries packet and burst framing. The output stream is cut into fixed-length packets. The final sample of each packet carries a packet-end flag. The whole final packet of a burst carries an end-of-burst flag, so the two flags rising together mark the close of the burst.

A burst is opened by a start pulse while the block is idle. The start pulse comes with a packet count and an optional scheduled transmit time, counted in master-clock cycles. The block latches these controls. When scheduling is requested, the 64-bit time and a has-time flag go out on every sample of the first packet only. Control changes made while a burst is running have no effect. A sticky underflow flag records any cycle in which the downstream side was ready during a burst but the source had no sample to offer.

Top module: `iq_burst_packer`

## Requirements
- R1: Each output word holds Q in bits 31:16 and I in bits 15:0 of the sample accepted on the input.
- R2: An output word transfers only on a clock edge where tx_valid_o and tx_ready_i are both high. While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and data, last, end-of-burst, has-time and timestamp hold their values.
- R3: Packets are PKT_LEN samples long (default 256). tx_last_o is high on the PKT_LEN-th sample of every packet and low on every other sample.
- R4: The packet count is latched at burst start, and a count of 0 is treated as 1. tx_eob_o is high on every sample of the final packet and low on the samples of earlier packets. The burst ends with the sample on which tx_last_o and tx_eob_o are both high.
- R5: If sched_en_i is high at burst start, tx_has_time_o is high and tx_time_o carries the latched sched_time_i on every sample of the first packet. On all other samples tx_has_time_o is low and tx_time_o is 0.
- R6: While a burst is running, changes to sched_en_i, sched_time_i, burst_pkts_i and burst_start_i have no effect on the output stream.
- R7: in_ready_o is low while no burst is running, so no sample is taken outside a burst. During a burst, in_ready_o is high only when the output register is empty or is being emptied in the same cycle.
- R8: underflow_o is set after any cycle that has a burst running, tx_ready_i high and in_valid_i low. It stays set until the next accepted burst start clears it.
- R9: After reset, tx_valid_o, in_ready_o and underflow_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when high with in_valid_i |
| in_i_i | input | 16 | In-phase sample |
| in_q_i | input | 16 | Quadrature sample |
| burst_start_i | input | 1 | Opens a burst when idle |
| burst_pkts_i | input | LEN_W | Packets in the burst (0 means 1) |
| sched_en_i | input | 1 | Attach a transmit time to the first packet |
| sched_time_i | input | 64 | Transmit time in master-clock cycles |
| tx_ready_i | input | 1 | Downstream ready |
| tx_valid_o | output | 1 | Output word valid |
| tx_data_o | output | 32 | Packed word {Q, I} |
| tx_last_o | output | 1 | Final sample of a packet |
| tx_eob_o | output | 1 | Sample belongs to the final packet of the burst |
| tx_has_time_o | output | 1 | tx_time_o carries a valid time |
| tx_time_o | output | 64 | Scheduled transmit time |
| underflow_o | output | 1 | Sticky source-underflow flag |

## Verification
The bench builds the block with PKT_LEN = 4 and LEN_W = 4. With these values, multi-packet bursts, every packet boundary and the end-of-burst packet are all reached within a few dozen samples. Downstream ready is driven both constantly high and in a pseudo-random pattern, which exercises the hold-while-stalled rule across packet and burst edges. Separate bursts cover a count of 0 and a count of 1, a mid-burst retrigger carrying a different time and length, and a deliberate source gap that raises the underflow flag.

// File: rtl/iq_tx_pkg.sv
package iq_tx_pkg;
  localparam int unsigned IQ_W   = 16;
  localparam int unsigned WORD_W = 2 * IQ_W;
  localparam int unsigned TS_W   = 64;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              last;
    logic              eob;
    logic              has_time;
    logic [TS_W-1:0]   ts;
  } tx_beat_t;
endpackage

// File: rtl/iq_word_pack.sv
module iq_word_pack
  import iq_tx_pkg::*;
(
  input  logic [IQ_W-1:0]   i_i,
  input  logic [IQ_W-1:0]   q_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned LANES = 2;
  logic [LANES-1:0][IQ_W-1:0] lane;
  assign lane[0] = i_i;
  assign lane[1] = q_i;

  // lane 0 = I in low half, lane 1 = Q in high half
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word_o[k*IQ_W +: IQ_W] = lane[k];
  end
endmodule

// File: rtl/iq_burst_ctrl.sv
module iq_burst_ctrl
  import iq_tx_pkg::*;
#(
  parameter int unsigned PKT_LEN = 256,
  parameter int unsigned LEN_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] pkts_i,
  input  logic             sched_i,
  input  logic [TS_W-1:0]  time_i,
  input  logic             take_i,
  input  logic             link_ready_i,
  input  logic             src_valid_i,
  output logic             active_o,
  output logic             last_o,
  output logic             eob_o,
  output logic             has_time_o,
  output logic [TS_W-1:0]  time_o,
  output logic             underflow_o
);
  localparam int unsigned CNT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PKT_LEN - 1);
  localparam logic [LEN_W-1:0] ONE_PKT  = LEN_W'(1);

  logic             active_q;
  logic [CNT_W-1:0] samp_q;
  logic [LEN_W-1:0] left_q;
  logic             first_q;
  logic             sched_q;
  logic [TS_W-1:0]  time_q;
  logic             uf_q;
  logic             open_burst;

  assign open_burst = start_i && !active_q;
  assign last_o     = (samp_q == CNT_LAST);
  assign eob_o      = (left_q == ONE_PKT);
  assign has_time_o = first_q && sched_q;
  assign time_o     = has_time_o ? time_q : '0;
  assign active_o   = active_q;
  assign underflow_o = uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      samp_q   <= '0;
      left_q   <= '0;
      first_q  <= 1'b0;
      sched_q  <= 1'b0;
      time_q   <= '0;
    end else if (open_burst) begin
      active_q <= 1'b1;
      samp_q   <= '0;
      left_q   <= (pkts_i == '0) ? ONE_PKT : pkts_i;
      first_q  <= 1'b1;
      sched_q  <= sched_i;
      time_q   <= time_i;
    end else if (take_i) begin
      if (last_o) begin
        samp_q  <= '0;
        first_q <= 1'b0;
        if (eob_o) active_q <= 1'b0;
        else       left_q   <= left_q - ONE_PKT;
      end else begin
        samp_q <= samp_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    uf_q <= 1'b0;
    else if (open_burst)                            uf_q <= 1'b0;
    else if (active_q && link_ready_i && !src_valid_i) uf_q <= 1'b1;
  end
endmodule

// File: rtl/iq_tx_stage.sv
module iq_tx_stage
  import iq_tx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  tx_beat_t beat_i,
  input  logic     ready_i,
  output logic     room_o,
  output logic     valid_o,
  output tx_beat_t beat_o
);
  logic valid_q;
  assign valid_o = valid_q;
  assign room_o  = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= 1'b0;
    else if (load_i)  valid_q <= 1'b1;
    else if (ready_i) valid_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (load_i) beat_o <= beat_i;
  end
endmodule

// File: rtl/iq_burst_packer.sv
module iq_burst_packer
  import iq_tx_pkg::*;
#(
  parameter int unsigned PKT_LEN = 256,
  parameter int unsigned LEN_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IQ_W-1:0]   in_i_i,
  input  logic [IQ_W-1:0]   in_q_i,
  input  logic              burst_start_i,
  input  logic [LEN_W-1:0]  burst_pkts_i,
  input  logic              sched_en_i,
  input  logic [TS_W-1:0]   sched_time_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [WORD_W-1:0] tx_data_o,
  output logic              tx_last_o,
  output logic              tx_eob_o,
  output logic              tx_has_time_o,
  output logic [TS_W-1:0]   tx_time_o,
  output logic              underflow_o
);
  logic     active, room, take;
  tx_beat_t beat_in, beat_out;

  assign in_ready_o = active && room;
  assign take       = in_valid_i && in_ready_o;

  iq_word_pack i_pack (
    .i_i    (in_i_i),
    .q_i    (in_q_i),
    .word_o (beat_in.word)
  );

  iq_burst_ctrl #(.PKT_LEN(PKT_LEN), .LEN_W(LEN_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (burst_start_i),
    .pkts_i       (burst_pkts_i),
    .sched_i      (sched_en_i),
    .time_i       (sched_time_i),
    .take_i       (take),
    .link_ready_i (tx_ready_i),
    .src_valid_i  (in_valid_i),
    .active_o     (active),
    .last_o       (beat_in.last),
    .eob_o        (beat_in.eob),
    .has_time_o   (beat_in.has_time),
    .time_o       (beat_in.ts),
    .underflow_o  (underflow_o)
  );

  iq_tx_stage i_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (take),
    .beat_i  (beat_in),
    .ready_i (tx_ready_i),
    .room_o  (room),
    .valid_o (tx_valid_o),
    .beat_o  (beat_out)
  );

  assign tx_data_o     = beat_out.word;
  assign tx_last_o     = beat_out.last;
  assign tx_eob_o      = beat_out.eob;
  assign tx_has_time_o = beat_out.has_time;
  assign tx_time_o     = beat_out.ts;
endmodule

// File: rtl/iq_burst_packer_chk.sv
module iq_burst_packer_chk
  import iq_tx_pkg::*;
#(
  parameter int unsigned PKT_LEN = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [IQ_W-1:0]   in_i_i,
  input logic [IQ_W-1:0]   in_q_i,
  input logic              burst_start_i,
  input logic              tx_ready_i,
  input logic              tx_valid_o,
  input logic [WORD_W-1:0] tx_data_o,
  input logic              tx_last_o,
  input logic              tx_eob_o,
  input logic              tx_has_time_o,
  input logic [TS_W-1:0]   tx_time_o,
  input logic              underflow_o
);
  localparam int unsigned CNT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PKT_LEN - 1);

  logic             acc, take;
  logic [CNT_W-1:0] seen_q;
  logic             eob_pend_q, mid_burst_q;

  assign acc  = tx_valid_o && tx_ready_i;
  assign take = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= '0;
      eob_pend_q  <= 1'b0;
      mid_burst_q <= 1'b0;
    end else if (acc) begin
      seen_q <= tx_last_o ? '0 : seen_q + CNT_W'(1);
      if (tx_last_o) begin
        eob_pend_q  <= 1'b0;
        mid_burst_q <= !tx_eob_o;
      end else if (tx_eob_o) begin
        eob_pend_q <= 1'b1;
      end
    end
  end

  a_r1_pack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> tx_data_o == {$past(in_q_i), $past(in_i_i)});

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)
      && $stable(tx_eob_o) && $stable(tx_has_time_o) && $stable(tx_time_o));

  a_r3_last_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_last_o == (seen_q == CNT_LAST)));

  a_r4_eob_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && eob_pend_q |-> tx_eob_o);

  a_r5_first_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && mid_burst_q |-> !tx_has_time_o);

  a_r5_time_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_has_time_o |-> tx_time_o == '0);

  a_r7_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (tx_ready_i || !tx_valid_o));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o && !burst_start_i |=> underflow_o);
endmodule

bind iq_burst_packer iq_burst_packer_chk #(.PKT_LEN(PKT_LEN)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .in_i_i        (in_i_i),
  .in_q_i        (in_q_i),
  .burst_start_i (burst_start_i),
  .tx_ready_i    (tx_ready_i),
  .tx_valid_o    (tx_valid_o),
  .tx_data_o     (tx_data_o),
  .tx_last_o     (tx_last_o),
  .tx_eob_o      (tx_eob_o),
  .tx_has_time_o (tx_has_time_o),
  .tx_time_o     (tx_time_o),
  .underflow_o   (underflow_o)
);

// File: tb/test_iq_burst_packer.sv
`timescale 1ns/1ps
module test_iq_burst_packer;
  localparam int P = 4;
  localparam int LW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 0, burst_start_i = 0, sched_en_i = 0, tx_ready_i = 0;
  logic [15:0] in_i_i = '0, in_q_i = '0;
  logic [LW-1:0] burst_pkts_i = '0;
  logic [63:0] sched_time_i = '0;
  logic in_ready_o, tx_valid_o, tx_last_o, tx_eob_o, tx_has_time_o, underflow_o;
  logic [31:0] tx_data_o;
  logic [63:0] tx_time_o;

  iq_burst_packer #(.PKT_LEN(P), .LEN_W(LW)) i_iq_burst_packer (.*);

  always #2 clk_i = ~clk_i;

  typedef struct { logic [31:0] d; logic l, e, h; logic [63:0] t; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] seq = 16'h0100;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready_i = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1 ? lfsr[0] : 1'b0);
  end

  // monitor: scoreboard pop and hold check
  bit prev_stall = 0;
  exp_t prev;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_stall) begin
        chk(tx_valid_o && tx_data_o == prev.d && tx_last_o == prev.l && tx_eob_o == prev.e
            && tx_has_time_o == prev.h && tx_time_o == prev.t,
            "R2", "hold while stalled", {31'd0, tx_valid_o, tx_data_o}, {32'd1, prev.d});
      end
      if (tx_valid_o && tx_ready_i) begin
        if (q.size() == 0) begin
          chk(0, "R7", "unexpected output word", {32'd0, tx_data_o}, 64'd0);
        end else begin
          exp_t x;
          x = q.pop_front();
          chk(tx_data_o == x.d, "R1", "data", {32'd0, tx_data_o}, {32'd0, x.d});
          chk(tx_last_o == x.l, "R3", "last", {63'd0, tx_last_o}, {63'd0, x.l});
          chk(tx_eob_o == x.e, "R4", "eob", {63'd0, tx_eob_o}, {63'd0, x.e});
          chk(tx_has_time_o == x.h && tx_time_o == x.t, "R5_R6", "time", tx_time_o, x.t);
        end
      end
      prev_stall = tx_valid_o && !tx_ready_i;
      prev.d = tx_data_o; prev.l = tx_last_o; prev.e = tx_eob_o;
      prev.h = tx_has_time_o; prev.t = tx_time_o;
    end
  end

  task automatic send_burst(int npk, logic [LW-1:0] len_f, bit sch, logic [63:0] ts,
                            bit perturb, bit gap);
    burst_start_i = 1; burst_pkts_i = len_f; sched_en_i = sch; sched_time_i = ts;
    in_valid_i = 1; in_i_i = seq; in_q_i = ~seq;
    @(posedge clk_i); #1;
    burst_start_i = 0;
    for (int s = 0; s < npk * P; s++) begin
      exp_t x;
      in_i_i = seq; in_q_i = ~seq ^ 16'h5A00;
      x.d = {in_q_i, in_i_i};
      x.l = (s % P) == P - 1;
      x.e = (s / P) == npk - 1;
      x.h = sch && (s < P);
      x.t = x.h ? ts : 64'd0;
      if (perturb && s == P + 1) begin   // R6: retrigger mid-burst
        burst_start_i = 1; burst_pkts_i = LW'(5); sched_en_i = 1; sched_time_i = 64'hDEAD_BEEF;
      end
      if (gap && s == 2) begin            // R8: source gap with ready high
        in_valid_i = 0;
        repeat (2) @(posedge clk_i);
        #1; in_valid_i = 1;
      end
      forever begin
        @(negedge clk_i);
        if (in_ready_o) begin
          q.push_back(x);
          @(posedge clk_i); #1;
          break;
        end
        @(posedge clk_i); #1;
      end
      burst_start_i = 0;
      seq++;
    end
    in_valid_i = 0;
    for (int k = 0; k < 200 && q.size() != 0; k++) @(posedge clk_i);
    #1;
    chk(q.size() == 0, "R4", "burst drained", 64'(q.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!tx_valid_o, "R9", "reset valid", {63'd0, tx_valid_o}, 64'd0);
    chk(!in_ready_o, "R9", "reset in_ready", {63'd0, in_ready_o}, 64'd0);
    chk(!underflow_o, "R9", "reset underflow", {63'd0, underflow_o}, 64'd0);
    @(posedge clk_i); #1; rst_ni = 1;
    // R7: idle, source offers data without a burst
    in_valid_i = 1; in_i_i = 16'h1234; in_q_i = 16'h4321;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk(!in_ready_o && !tx_valid_o, "R7", "idle accepts nothing",
          {62'd0, in_ready_o, tx_valid_o}, 64'd0);
    end
    @(posedge clk_i); #1; in_valid_i = 0;

    rdy_mode = 0;
    send_burst(3, LW'(3), 1, 64'h0000_0012_3456_789A, 0, 0);
    rdy_mode = 1;
    send_burst(1, LW'(1), 0, 64'hFFFF_0000_0000_0001, 0, 0);   // R4 length one, R5 no time
    send_burst(2, LW'(2), 1, 64'h8000_0000_0000_0003, 1, 0);   // R6 retrigger ignored
    send_burst(1, LW'(0), 1, 64'h0000_0000_0000_0042, 0, 0);   // R4 zero treated as one
    send_burst(3, LW'(3), 0, 64'd0, 0, 0);
    @(negedge clk_i);
    chk(!underflow_o, "R8", "no underflow on clean bursts", {63'd0, underflow_o}, 64'd0);
    rdy_mode = 0;
    send_burst(1, LW'(1), 0, 64'd0, 0, 1);
    @(negedge clk_i);
    chk(underflow_o, "R8", "underflow after gap", {63'd0, underflow_o}, 64'd1);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(underflow_o, "R8", "underflow sticky", {63'd0, underflow_o}, 64'd1);
    @(posedge clk_i); #1;
    send_burst(2, LW'(2), 1, 64'h55, 0, 0);
    @(negedge clk_i);
    chk(!underflow_o, "R8", "underflow cleared by start", {63'd0, underflow_o}, 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule